// File: doc/BRIEF.md
# SDRAM Host Initialization and Access Controller

This block sits between a simple host request port and a 16-bit, two-bank SDRAM. Coming out of reset, it holds the clock enable low and then runs the power-up procedure on its own. First it waits a programmable number of idle cycles. It then closes every bank, issues a fixed number of auto-refresh commands and programs the mode register. Host accesses are refused until all of that is done.

Once initialized, the controller takes one access at a time. The host raises `req` and holds it, together with a read/write flag, bank, row, column, write data and a per-byte write mask, until `ack` pulses. Each access opens the row. Then, after the activate-to-column delay, it issues a column command with auto-precharge, so no row stays open between requests. Read data is sampled a CAS latency after the read command. A free-running interval timer raises a refresh need. That need is served before the next host access whenever the controller is between accesses.

All minimum spacings are given as clock-count parameters: activate-to-column, activate-to-precharge, precharge period, row/refresh cycle and mode-set recovery. The controller never issues two commands closer than these counts allow.

Top module: `sdram_host_ctrl`

## Requirements
- R1: While `rst` is high, `sd_cke` is 0 and the command pins hold NOP ({cs,ras,cas,we} = 0111). After `rst` falls, `sd_cke` is 1 and at least INIT_WAIT cycles pass before the first non-NOP command.
- R2: The first command after reset is PRECHARGE ({cs,ras,cas,we}=0010) with `sd_addr[10]`=1 (all banks). Exactly INIT_REFS auto-refresh commands (0001) follow. The first comes at least T_RP cycles after the precharge, and consecutive refreshes are at least T_RC cycles apart.
- R3: Initialization ends with one MODE SET command (0000) on bank 0. Its `sd_addr` value has bits [2:0]=000 (burst of one), bit 3=0 (sequential), bits [6:4] equal to CAS_LAT and bits [10:7]=0.
- R4: An access issues ACTIVATE (0011) with the bank on `sd_ba` and the row on `sd_addr`. Exactly T_RCD cycles later it issues READ (0101) or WRITE (0100) on the same bank, with `sd_addr[7:0]` = column, `sd_addr[9:8]`=0 and `sd_addr[10]`=1 (auto-precharge).
- R5: In the WRITE command cycle, `sd_dq_oe`=1, `sd_dq_out` equals the request data and `sd_dqm` equals the request mask. Mask bit 1 covers DQ[15:8] and bit 0 covers DQ[7:0], and a 1 blocks that byte. `sd_dq_oe` is 0 in every other cycle.
- R6: For a read, `rsp_rdata` takes `sd_dq_in` as it stands CAS_LAT cycles after the READ command cycle, and `ack` pulses for one cycle in the cycle that follows. For a write, `ack` pulses in the WRITE command cycle.
- R7: Two ACTIVATE commands are at least T_RC cycles apart and at least T_RAS+T_RP cycles apart.
- R8: After initialization an auto-refresh is issued every REFRESH_INTERVAL cycles while idle. Under a continuous stream of requests, a pending refresh is issued before the next access, so consecutive refreshes are never more than REFRESH_INTERVAL plus one access time apart.
- R9: A request raised during initialization produces no ACTIVATE, READ or WRITE before the MODE SET command.
- R10: `sd_dqm` is 11 from reset until the MODE SET command, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_bank | input | 1 | Bank select |
| req_row | input | 11 | Row address |
| req_col | input | 8 | Column address |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 2 | Per-byte write block (1 = byte not written) |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data, valid with `ack` for reads |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank address |
| sd_addr | output | 11 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte masks, bit 1 upper byte |
| sd_dq_out | output | 16 | Write data toward the data bus |
| sd_dq_oe | output | 1 | Data bus output enable |
| sd_dq_in | input | 16 | Data bus as read back from the device |

## Verification
The assertions assume that the host keeps `req` and its fields stable from raising it until `ack`, and keeps only one access outstanding. They also assume the timing parameters are at least 2 and CAS_LAT is 2 or 3. The bench meets these conditions: each access task holds the request, drops it on the `ack` cycle and only then starts the next one. The bench's device model drives the addressed data word on `sd_dq_in` only in the single cycle one CAS latency after a READ, and drives a fixed junk word in every other cycle. A capture made in the wrong cycle therefore returns the wrong value.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam int DQ_W   = 16;
    localparam int MASK_W = DQ_W / 8;
    localparam int BANK_W = 1;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 8;
    localparam int ADDR_W = 11;
    localparam int AP_BIT = 10;   // auto-precharge / all-banks select

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PALL,
        ST_IREF,
        ST_LMR,
        ST_IDLE,
        ST_COL
    } ctl_st_e;

    typedef struct packed {
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   wdata;
        logic [MASK_W-1:0] wmask;
    } acc_req_s;

    typedef struct packed {
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] ba;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] dqm;
        logic              oe;
        logic [DQ_W-1:0]   dq;
    } pin_drv_s;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // burst of one, sequential order, latency in [6:4], burst writes
    function automatic logic [ADDR_W-1:0] mode_word(int cl);
        logic [ADDR_W-1:0] w;
        w      = '0;
        w[6:4] = cl[2:0];
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] col_word(logic [COL_W-1:0] c);
        logic [ADDR_W-1:0] w;
        w             = '0;
        w[COL_W-1:0]  = c;
        w[AP_BIT]     = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
    parameter int INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic take,
    output logic due
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (cnt == W'(INTERVAL - 1)) begin
            cnt <= '0;
            due <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
            if (take) due <= 1'b0;
        end
    end

    // R8
    due_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && due && !take) |=> due);

endmodule

// File: rtl/sdc_rd_capture.sv
module sdc_rd_capture
    import sdc_pkg::*;
#(
    parameter int CL = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [DQ_W-1:0] dq_in,
    output logic            valid,
    output logic [DQ_W-1:0] data
);
    logic [CL:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe  <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            pipe  <= {pipe[CL-1:0], start};
            valid <= pipe[CL];
            if (pipe[CL]) data <= dq_in;
        end
    end

    // R6
    rd_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (pipe == '0));

endmodule

// File: rtl/sdram_host_ctrl.sv
module sdram_host_ctrl
    import sdc_pkg::*;
#(
    parameter int INIT_WAIT    = 12500,
    parameter int INIT_REFS    = 8,
    parameter int T_RCD        = 3,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_MRD        = 2,
    parameter int CAS_LAT      = 2,
    parameter int REFRESH_INTERVAL = 1950
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [MASK_W-1:0] req_wmask,
    output logic              ack,
    output logic [DQ_W-1:0]   rsp_rdata,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    // cycles from column command to the next command: covers row
    // cycle, row-active minimum plus precharge, and read return
    localparam int TAIL  = imax(imax(T_RC - T_RCD, imax(T_RAS - T_RCD, 2) + T_RP),
                                CAS_LAT + 2);
    localparam int CNT_W = $clog2(imax(INIT_WAIT, 256)) + 1;
    localparam int RF_W  = $clog2(INIT_REFS + 1);

    function automatic logic [CNT_W-1:0] hold_load(int n);
        return (n > 2) ? CNT_W'(n - 2) : '0;
    endfunction

    ctl_st_e          st, ret_st;
    logic [CNT_W-1:0] wcnt;
    logic [RF_W-1:0]  refs_left;
    logic             mode_set;
    logic             cke_q;
    logic             ack_q;
    acc_req_s         req_q;
    pin_drv_s         pins_q;

    logic             ref_due;
    logic             ref_take;
    logic             rd_go;
    logic             cap_valid;
    logic [DQ_W-1:0]  cap_data;

    assign ref_take = (st == ST_IDLE) && ref_due;
    assign rd_go    = (st == ST_COL) && !req_q.we;

    sdc_refresh_timer #(
        .INTERVAL (REFRESH_INTERVAL)
    ) i_ref_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (mode_set),
        .take (ref_take),
        .due  (ref_due)
    );

    sdc_rd_capture #(
        .CL (CAS_LAT)
    ) i_rd_capture (
        .clk   (clk),
        .rst   (rst),
        .start (rd_go),
        .dq_in (sd_dq_in),
        .valid (cap_valid),
        .data  (cap_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HOLD;
            ret_st    <= ST_PALL;
            wcnt      <= hold_load(INIT_WAIT);
            refs_left <= '0;
            mode_set  <= 1'b0;
            cke_q     <= 1'b0;
            ack_q     <= 1'b0;
            req_q     <= '0;
            pins_q    <= '{cmd: CMD_NOP, ba: '0, addr: '0, dqm: '1, oe: 1'b0, dq: '0};
        end else begin
            cke_q      <= 1'b1;
            ack_q      <= 1'b0;
            pins_q.cmd <= CMD_NOP;
            pins_q.oe  <= 1'b0;
            pins_q.dqm <= mode_set ? '0 : '1;
            unique case (st)
                ST_HOLD: begin
                    if (wcnt == '0) st <= ret_st;
                    else            wcnt <= wcnt - 1'b1;
                end
                ST_PALL: begin
                    pins_q.cmd   <= CMD_PRE;
                    pins_q.addr  <= '0;
                    pins_q.addr[AP_BIT] <= 1'b1;
                    refs_left    <= RF_W'(INIT_REFS);
                    st           <= ST_HOLD;
                    wcnt         <= hold_load(T_RP);
                    ret_st       <= ST_IREF;
                end
                ST_IREF: begin
                    pins_q.cmd <= CMD_REF;
                    refs_left  <= refs_left - 1'b1;
                    st         <= ST_HOLD;
                    wcnt       <= hold_load(T_RC);
                    ret_st     <= (refs_left == RF_W'(1)) ? ST_LMR : ST_IREF;
                end
                ST_LMR: begin
                    pins_q.cmd  <= CMD_MRS;
                    pins_q.ba   <= '0;
                    pins_q.addr <= mode_word(CAS_LAT);
                    mode_set    <= 1'b1;
                    st          <= ST_HOLD;
                    wcnt        <= hold_load(T_MRD);
                    ret_st      <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_due) begin
                        pins_q.cmd <= CMD_REF;
                        st         <= ST_HOLD;
                        wcnt       <= hold_load(T_RC);
                        ret_st     <= ST_IDLE;
                    end else if (req) begin
                        req_q       <= '{we: req_we, bank: req_bank, row: req_row,
                                         col: req_col, wdata: req_wdata, wmask: req_wmask};
                        pins_q.cmd  <= CMD_ACT;
                        pins_q.ba   <= req_bank;
                        pins_q.addr <= req_row;
                        st          <= ST_HOLD;
                        wcnt        <= hold_load(T_RCD);
                        ret_st      <= ST_COL;
                    end
                end
                ST_COL: begin
                    pins_q.cmd  <= req_q.we ? CMD_WR : CMD_RD;
                    pins_q.ba   <= req_q.bank;
                    pins_q.addr <= col_word(req_q.col);
                    if (req_q.we) begin
                        pins_q.oe  <= 1'b1;
                        pins_q.dq  <= req_q.wdata;
                        pins_q.dqm <= req_q.wmask;
                        ack_q      <= 1'b1;
                    end
                    st     <= ST_HOLD;
                    wcnt   <= hold_load(TAIL);
                    ret_st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins_q.cmd;
    assign sd_cke    = cke_q;
    assign sd_ba     = pins_q.ba;
    assign sd_addr   = pins_q.addr;
    assign sd_dqm    = pins_q.dqm;
    assign sd_dq_out = pins_q.dq;
    assign sd_dq_oe  = pins_q.oe;
    assign ack       = ack_q | cap_valid;
    assign rsp_rdata = cap_data;

    // spacing monitors for the properties below
    logic [7:0] gap_act, gap_ref, gap_pre;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_act <= 8'hFF;
            gap_ref <= 8'hFF;
            gap_pre <= 8'hFF;
        end else begin
            if (pins_q.cmd == CMD_ACT)  gap_act <= 8'd1;
            else if (gap_act != 8'hFF)  gap_act <= gap_act + 8'd1;
            if (pins_q.cmd == CMD_REF)  gap_ref <= 8'd1;
            else if (gap_ref != 8'hFF)  gap_ref <= gap_ref + 8'd1;
            if (pins_q.cmd == CMD_PRE)  gap_pre <= 8'd1;
            else if (gap_pre != 8'hFF)  gap_pre <= gap_pre + 8'd1;
        end
    end

    // R4
    rcd_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pins_q.cmd == CMD_RD || pins_q.cmd == CMD_WR) |-> gap_act >= 8'(T_RCD));

    // R7
    act_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pins_q.cmd == CMD_ACT) |-> gap_act >= 8'(imax(T_RC, T_RAS + T_RP)));

    // R2
    ref_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pins_q.cmd == CMD_REF) |-> (gap_ref >= 8'(T_RC) && gap_pre >= 8'(T_RP)));

    // R9
    early_access_chk: assert property (@(posedge clk) disable iff (rst)
        (pins_q.cmd == CMD_ACT || pins_q.cmd == CMD_RD || pins_q.cmd == CMD_WR) |-> mode_set);

    // R5
    oe_write_chk: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (pins_q.cmd == CMD_WR));

    // R10
    dqm_init_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_set |=> (sd_dqm == '1));

endmodule

// File: tb/test_sdram_host_ctrl.sv
module test_sdram_host_ctrl;

    localparam int INIT_WAIT = 300;
    localparam int REF_INT   = 150;
    localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RC = 9, T_MRD = 2, CL = 2;
    localparam int INIT_REFS = 8;
    localparam int LOG_N = 1024;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0, req_bank = 1'b0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_wmask = '0;
    logic        ack;
    logic [15:0] rsp_rdata;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_dq_oe;
    logic [10:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = 16'hBAD0;

    int n_chk = 0, n_err = 0, cyc = 0, rel_cyc = 0;
    bit done = 1'b0;

    sdram_host_ctrl #(
        .INIT_WAIT (INIT_WAIT), .INIT_REFS (INIT_REFS), .T_RCD (T_RCD),
        .T_RAS (T_RAS), .T_RP (T_RP), .T_RC (T_RC), .T_MRD (T_MRD),
        .CAS_LAT (CL), .REFRESH_INTERVAL (REF_INT)
    ) i_sdram_host_ctrl (
        .clk (clk), .rst (rst), .req (req), .req_we (req_we),
        .req_bank (req_bank), .req_row (req_row), .req_col (req_col),
        .req_wdata (req_wdata), .req_wmask (req_wmask), .ack (ack),
        .rsp_rdata (rsp_rdata), .sd_cke (sd_cke), .sd_cs_n (sd_cs_n),
        .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_ba (sd_ba), .sd_addr (sd_addr), .sd_dqm (sd_dqm),
        .sd_dq_out (sd_dq_out), .sd_dq_oe (sd_dq_oe), .sd_dq_in (sd_dq_in)
    );

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    // command log and device model
    int          lg_cyc [LOG_N];
    logic [3:0]  lg_cmd [LOG_N];
    logic [10:0] lg_addr[LOG_N];
    logic        lg_ba  [LOG_N];
    logic [1:0]  lg_dqm [LOG_N];
    logic        lg_oe  [LOG_N];
    logic [15:0] lg_dq  [LOG_N];
    int          lg_n = 0;
    int          oe_bad = 0, dqm_bad = 0, rd_at = -100;
    bit          mode_seen = 1'b0;
    logic [10:0] open_row[2];
    logic [15:0] rd_val = '0;

    function automatic logic [15:0] pat(logic b, logic [10:0] row, logic [7:0] col);
        return {b, row[6:0], col};
    endfunction

    always @(negedge clk) begin
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (!rst) begin
            if (!mode_seen && sd_dqm != 2'b11) dqm_bad++;
            if (sd_dq_oe && c != C_WR) oe_bad++;
            if (c == C_MRS) mode_seen = 1'b1;
            if (c == C_ACT) open_row[sd_ba] = sd_addr;
            if (c == C_RD) begin
                rd_at  = cyc;
                rd_val = pat(sd_ba, open_row[sd_ba], sd_addr[7:0]);
            end
            if (c != C_NOP && lg_n < LOG_N) begin
                lg_cyc[lg_n] = cyc;  lg_cmd[lg_n] = c;  lg_addr[lg_n] = sd_addr;
                lg_ba[lg_n] = sd_ba; lg_dqm[lg_n] = sd_dqm; lg_oe[lg_n] = sd_dq_oe;
                lg_dq[lg_n] = sd_dq_out;
                lg_n++;
            end
        end
        sd_dq_in = (cyc == rd_at + CL) ? rd_val : 16'hBAD0;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int find_cmd(int from, logic [3:0] c);
        for (int i = from; i < lg_n; i++) if (lg_cmd[i] == c) return i;
        return -1;
    endfunction

    function automatic int find_col(int from);
        for (int i = from; i < lg_n; i++)
            if (lg_cmd[i] == C_RD || lg_cmd[i] == C_WR) return i;
        return -1;
    endfunction

    task automatic do_access(input bit we, input logic b, input logic [10:0] row,
                             input logic [7:0] col, input logic [15:0] wd,
                             input logic [1:0] wm, output int ai, output int ci,
                             output int ack_at, output logic [15:0] rd);
        int start;
        start = lg_n;
        @(negedge clk);
        req_we = we; req_bank = b; req_row = row; req_col = col;
        req_wdata = wd; req_wmask = wm; req = 1'b1;
        do @(negedge clk); while (!ack);
        ack_at = cyc; rd = rsp_rdata; req = 1'b0;
        @(posedge clk); #1;
        ai = find_cmd(start, C_ACT);
        ci = (ai < 0) ? -1 : find_col(ai + 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sd_cke == 1'b0, "R1 cke in reset", sd_cke, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 nop in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        rst = 1'b0; rel_cyc = cyc;
        @(negedge clk);
        chk(sd_cke == 1'b1, "R1 cke after reset", sd_cke, 1);
    endtask

    task automatic t_init_and_early_read();
        int ai, ci, ack_at, refs, ok;
        logic [15:0] rd;
        do_access(1'b0, 1'b1, 11'h155, 8'h3C, '0, '0, ai, ci, ack_at, rd);
        chk(lg_cmd[0] == C_PRE && lg_addr[0][10], "R2 first cmd precharge-all", lg_cmd[0], C_PRE);
        chk(lg_cyc[0] - rel_cyc >= INIT_WAIT, "R1 power-up wait", lg_cyc[0] - rel_cyc, INIT_WAIT);
        refs = 0; ok = 1;
        for (int i = 1; i <= INIT_REFS; i++) begin
            if (lg_cmd[i] == C_REF) refs++;
            if (i == 1 && lg_cyc[1] - lg_cyc[0] < T_RP) ok = 0;
            if (i > 1 && lg_cyc[i] - lg_cyc[i-1] < T_RC) ok = 0;
        end
        chk(refs == INIT_REFS, "R2 init refresh count", refs, INIT_REFS);
        chk(ok == 1, "R2 init spacing", ok, 1);
        chk(lg_cmd[INIT_REFS+1] == C_MRS, "R3 mode set follows", lg_cmd[INIT_REFS+1], C_MRS);
        chk(lg_addr[INIT_REFS+1] == 11'(CL << 4) && lg_ba[INIT_REFS+1] == 1'b0,
            "R3 mode word", lg_addr[INIT_REFS+1], CL << 4);
        chk(ai == INIT_REFS + 2, "R9 first activate after mode set", ai, INIT_REFS + 2);
        if (ci < 0) begin
            chk(1'b0, "R4 read command present", ci, 0);
            return;
        end
        chk(lg_ba[ai] == 1'b1 && lg_addr[ai] == 11'h155, "R4 activate bank/row", lg_addr[ai], 11'h155);
        chk(lg_cmd[ci] == C_RD && lg_addr[ci] == 11'h43C && lg_ba[ci] == 1'b1,
            "R4 read column with auto-precharge", lg_addr[ci], 11'h43C);
        chk(lg_cyc[ci] - lg_cyc[ai] == T_RCD, "R4 activate-to-read", lg_cyc[ci] - lg_cyc[ai], T_RCD);
        chk(ack_at == lg_cyc[ci] + CL + 1, "R6 read ack cycle", ack_at, lg_cyc[ci] + CL + 1);
        chk(rd == pat(1'b1, 11'h155, 8'h3C), "R6 read data", rd, pat(1'b1, 11'h155, 8'h3C));
        chk(dqm_bad == 0, "R10 mask high during init", dqm_bad, 0);
    endtask

    task automatic t_write(input logic b, input logic [10:0] row, input logic [7:0] col,
                           input logic [15:0] wd, input logic [1:0] wm);
        int ai, ci, ack_at;
        logic [15:0] rd;
        do_access(1'b1, b, row, col, wd, wm, ai, ci, ack_at, rd);
        if (ci < 0) begin
            chk(1'b0, "R4 write command present", ci, 0);
            return;
        end
        chk(lg_cmd[ci] == C_WR && lg_addr[ci] == {1'b1, 2'b00, col} && lg_ba[ci] == b,
            "R4 write column with auto-precharge", lg_addr[ci], {1'b1, 2'b00, col});
        chk(lg_oe[ci] && lg_dq[ci] == wd, "R5 write data driven", lg_dq[ci], wd);
        chk(lg_dqm[ci] == wm, "R5 byte mask", lg_dqm[ci], wm);
        chk(ack_at == lg_cyc[ci], "R6 write ack cycle", ack_at, lg_cyc[ci]);
    endtask

    task automatic t_act_spacing();
        int a1, c1, a2, c2, k;
        logic [15:0] rd;
        do_access(1'b1, 1'b0, 11'h021, 8'h10, 16'h0F0F, 2'b00, a1, c1, k, rd);
        do_access(1'b1, 1'b0, 11'h022, 8'h11, 16'hF0F0, 2'b00, a2, c2, k, rd);
        if (a1 < 0 || a2 < 0) begin
            chk(1'b0, "R7 activates present", a2, 0);
            return;
        end
        chk(lg_cyc[a2] - lg_cyc[a1] >= T_RC, "R7 activate gap vs row cycle",
            lg_cyc[a2] - lg_cyc[a1], T_RC);
        chk(lg_cyc[a2] - lg_cyc[a1] >= T_RAS + T_RP, "R7 activate gap vs active+precharge",
            lg_cyc[a2] - lg_cyc[a1], T_RAS + T_RP);
    endtask

    task automatic ref_gaps(input int from, output int cnt, output int maxgap);
        int last;
        cnt = 0; maxgap = 0; last = -1;
        for (int i = from; i < lg_n; i++) if (lg_cmd[i] == C_REF) begin
            cnt++;
            if (last >= 0 && lg_cyc[i] - last > maxgap) maxgap = lg_cyc[i] - last;
            last = lg_cyc[i];
        end
    endtask

    task automatic t_refresh_idle();
        int start, cnt, maxgap;
        start = lg_n;
        repeat (3 * REF_INT) @(negedge clk);
        ref_gaps(start, cnt, maxgap);
        chk(cnt >= 2, "R8 idle refresh count", cnt, 2);
        chk(maxgap <= REF_INT + 2, "R8 idle refresh period", maxgap, REF_INT);
    endtask

    task automatic t_refresh_priority();
        int start, cnt, maxgap, bad, ai, ci, k;
        logic [15:0] rd;
        start = lg_n; bad = 0;
        for (int i = 0; i < 40; i++) begin
            do_access(1'b0, i[0], 11'(i * 3), 8'(i * 5), '0, '0, ai, ci, k, rd);
            if (rd != pat(i[0], 11'(i * 3), 8'(i * 5))) bad++;
        end
        ref_gaps(start, cnt, maxgap);
        chk(bad == 0, "R6 streamed read data", bad, 0);
        chk(cnt >= 2, "R8 refresh under load", cnt, 2);
        chk(maxgap <= REF_INT + 20, "R8 refresh gap under load", maxgap, REF_INT + 20);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_init_and_early_read();
        t_write(1'b0, 11'h0AA, 8'h05, 16'hA5C3, 2'b00);
        t_write(1'b1, 11'h7FF, 8'hFF, 16'h1234, 2'b01);
        t_write(1'b0, 11'h001, 8'h80, 16'hBEEF, 2'b10);
        t_act_spacing();
        t_refresh_idle();
        t_refresh_priority();
        chk(oe_bad == 0, "R5 output enable only on write", oe_bad, 0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

endmodule